// File: doc/BRIEF.md
# Two-Step Subranging Flash Sequencer

This block is the digital control and decode core of a converter that resolves a 10-bit code in two flash passes over one shared bank of 16 comparators. A pulse on `start` begins a conversion. First, six coarse estimator comparators place the held input roughly on the scale. The sequencer then connects the shared bank to a window of 16 reference taps. The window is chosen so that it reaches one sixteenth of full scale past the estimated region on both sides. The bank's thermometer output gives the six upper bits. The same bank is next switched onto a fine ladder of 1-LSB steps, measured above the coarse tap just below the input, and that pass gives the four lower bits.

The comparators, ladders and sample-hold sit outside the block. It only drives the window base (`winBase`), the coarse tap for the residue (`coarseTap`) and the ladder select (`bankFine`). It samples the comparator outputs at the end of each phase. Each phase lasts a set number of clock cycles, chosen by a parameter. The finished code and an edge-saturation flag are latched together, and `done` is pulsed for one cycle.

Top module: `subflash_seq`

## Requirements
- R1: After reset, result, overrange, done, bankFine and winBase are all zero.
- R2: Reference tap t lies at t×16 LSB. Coarse estimator comparator k (k = 0..5) switches at (2k+3)×64 LSB. The window base equals 8 × (number of ones in estCmp), so it ranges over 0..48. It is output from the coarse phase onwards and holds until the next conversion begins.
- R3: In the coarse phase, bank bit j (j = 0..15) means the input is at or above tap winBase+j+1. The coarse code is winBase plus the ones in bankCmp, capped at 63, and it appears on coarseTap during the fine phase.
- R4: bankFine is high for exactly the fine phase. Fine bank bit j means the input minus coarseTap×16 is at least j+1 LSB. The fine value is the ones count capped at 15. The result is coarse×16 + fine, so an input of 0 gives 0 and an input of 1023 gives 1023.
- R5: An estimator error of up to 64 LSB either way still gives the exact code.
- R6: Thermometer inputs are decoded by counting ones, so a bubble pattern decodes the same as a clean code with the same number of ones.
- R7: overrange is set when the coarse bank reads all zeros while winBase is nonzero, or all ones while winBase is not 48. It is published together with the result, and the clamped code is still produced.
- R8: done rises exactly EST_CYC+CRS_CYC+FINE_CYC cycles after the clock edge that samples start. It stays high for one cycle, and the fine phase leads directly into it.
- R9: start is ignored while a conversion is running. It causes no second conversion and no extra done.
- R10: result and overrange change only in the cycle where done is high, and they hold their values between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, sampled when idle |
| estCmp | input | 6 | Coarse estimator thermometer |
| bankCmp | input | 16 | Shared comparator bank thermometer |
| winBase | output | 6 | Tap index at the base of the coarse window |
| coarseTap | output | 6 | Coarse code, tap subtracted for the fine residue |
| bankFine | output | 1 | High while the bank is on the fine ladder |
| result | output | 10 | Latched conversion code |
| done | output | 1 | One-cycle completion pulse |
| overrange | output | 1 | Coarse flash saturated at an inner window edge |

## Verification
The bench builds the sequencer with phase lengths of 2, 3 and 2 cycles. With these values the phase counters run through more than one count, and the window and coarse-tap outputs can be seen in the middle of a conversion. The analog model shifts the estimator input by up to ±64 LSB, and further to force saturation. It also flips bank bits to make bubbles. This covers the codes at both ends of the scale, the estimator thresholds, the windows at top and bottom, and the inner window edges where overrange is raised.

// File: rtl/subflash_pkg.sv
package subflash_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EST,
    S_CRS,
    S_FINE,
    S_LATCH
  } phase_e;

  typedef struct packed {
    logic capEst;
    logic capCoarse;
    logic capFine;
  } strobe_t;

  // population count; bubble-tolerant thermometer decode
  function automatic int onesOf(input logic [63:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) n += 32'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/subflash_ctrl.sv
module subflash_ctrl
  import subflash_pkg::*;
#(
  parameter int EST_CYC  = 1,
  parameter int CRS_CYC  = 2,
  parameter int FINE_CYC = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t ctl,
  output logic    bankFine,
  output logic    done
);
  localparam int MAXC = (EST_CYC > CRS_CYC) ?
                        ((EST_CYC > FINE_CYC) ? EST_CYC : FINE_CYC) :
                        ((CRS_CYC > FINE_CYC) ? CRS_CYC : FINE_CYC);
  localparam int CW = $clog2(MAXC) + 1;

  phase_e state, nxt;
  logic [CW-1:0] cnt;
  int   phaseLen;
  logic lastCyc;

  always_comb begin
    case (state)
      S_EST:   phaseLen = EST_CYC;
      S_CRS:   phaseLen = CRS_CYC;
      S_FINE:  phaseLen = FINE_CYC;
      default: phaseLen = 1;
    endcase
    lastCyc = (int'(cnt) == phaseLen - 1);
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (start) nxt = S_EST;
      S_EST:   if (lastCyc) nxt = S_CRS;
      S_CRS:   if (lastCyc) nxt = S_FINE;
      S_FINE:  if (lastCyc) nxt = S_LATCH;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    ctl.capEst    = (state == S_EST)  && lastCyc;
    ctl.capCoarse = (state == S_CRS)  && lastCyc;
    ctl.capFine   = (state == S_FINE) && lastCyc;
    bankFine      = (state == S_FINE);
    done          = (state == S_LATCH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state || state == S_IDLE) cnt <= '0;
      else                                 cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/subflash_dp.sv
module subflash_dp
  import subflash_pkg::*;
#(
  parameter int NEST      = 6,
  parameter int NBANK     = 16,
  parameter int CRS_BITS  = 6,
  parameter int FINE_BITS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       ctl,
  input  logic [NEST-1:0]               estCmp,
  input  logic [NBANK-1:0]              bankCmp,
  output logic [CRS_BITS-1:0]           winBase,
  output logic [CRS_BITS-1:0]           coarseTap,
  output logic [CRS_BITS+FINE_BITS-1:0] result,
  output logic                          overrange
);
  localparam int NTAPS    = 1 << CRS_BITS;
  localparam int TOPBASE  = NTAPS - NBANK;
  localparam int WIN_STEP = TOPBASE / NEST;
  localparam int MAXFINE  = (1 << FINE_BITS) - 1;

  int   estOnes, bankOnes, baseNext, coarseSum, coarseNext, fineNext;
  logic edgeHit, flagPend;

  always_comb begin
    estOnes    = onesOf(64'(estCmp));
    bankOnes   = onesOf(64'(bankCmp));
    baseNext   = (estOnes * WIN_STEP > TOPBASE) ? TOPBASE : estOnes * WIN_STEP;
    coarseSum  = int'(winBase) + bankOnes;
    coarseNext = (coarseSum > NTAPS - 1) ? NTAPS - 1 : coarseSum;
    edgeHit    = (bankOnes == 0 && winBase != '0) ||
                 (bankOnes == NBANK && int'(winBase) != TOPBASE);
    fineNext   = (bankOnes > MAXFINE) ? MAXFINE : bankOnes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winBase   <= '0;
      coarseTap <= '0;
      flagPend  <= 1'b0;
      result    <= '0;
      overrange <= 1'b0;
    end else begin
      if (ctl.capEst) winBase <= CRS_BITS'(baseNext);
      if (ctl.capCoarse) begin
        coarseTap <= CRS_BITS'(coarseNext);
        flagPend  <= edgeHit;
      end
      if (ctl.capFine) begin
        result    <= {coarseTap, FINE_BITS'(fineNext)};
        overrange <= flagPend;
      end
    end
  end

endmodule

// File: rtl/subflash_seq.sv
module subflash_seq
  import subflash_pkg::*;
#(
  parameter int NEST     = 6,
  parameter int NBANK    = 16,
  parameter int RES_BITS = 10,
  parameter int EST_CYC  = 1,
  parameter int CRS_CYC  = 2,
  parameter int FINE_CYC = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               start,
  input  logic [NEST-1:0]                    estCmp,
  input  logic [NBANK-1:0]                   bankCmp,
  output logic [RES_BITS-$clog2(NBANK)-1:0]  winBase,
  output logic [RES_BITS-$clog2(NBANK)-1:0]  coarseTap,
  output logic                               bankFine,
  output logic [RES_BITS-1:0]                result,
  output logic                               done,
  output logic                               overrange
);
  localparam int FINE_BITS = $clog2(NBANK);
  localparam int CRS_BITS  = RES_BITS - FINE_BITS;

  strobe_t ctl;

  subflash_ctrl #(
    .EST_CYC (EST_CYC),
    .CRS_CYC (CRS_CYC),
    .FINE_CYC(FINE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ctl     (ctl),
    .bankFine(bankFine),
    .done    (done)
  );

  subflash_dp #(
    .NEST     (NEST),
    .NBANK    (NBANK),
    .CRS_BITS (CRS_BITS),
    .FINE_BITS(FINE_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .estCmp   (estCmp),
    .bankCmp  (bankCmp),
    .winBase  (winBase),
    .coarseTap(coarseTap),
    .result   (result),
    .overrange(overrange)
  );

endmodule

// File: rtl/subflash_seq_chk.sv
module subflash_seq_chk #(
  parameter int NBANK    = 16,
  parameter int RES_BITS = 10
) (
  input logic                              clk,
  input logic                              rstN,
  input logic [RES_BITS-$clog2(NBANK)-1:0] winBase,
  input logic                              bankFine,
  input logic [RES_BITS-1:0]               result,
  input logic                              done,
  input logic                              overrange
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_fine_to_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bankFine) |-> done);

  assert_window_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (bankFine && $past(bankFine)) |-> $stable(winBase));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (result != $past(result)) |-> done);

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (overrange != $past(overrange)) |-> done);

endmodule

bind subflash_seq subflash_seq_chk #(.NBANK(NBANK), .RES_BITS(RES_BITS)) u_chk (.*);

// File: tb/subflash_seq_bench.sv
module subflash_seq_bench;
  localparam int EST = 2;
  localparam int CRS = 3;
  localparam int FIN = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [5:0]  estCmp;
  logic [15:0] bankCmp;
  logic [5:0]  winBase, coarseTap;
  logic        bankFine, done, overrange;
  logic [9:0]  result;

  int vinA = 0;
  int errA = 0;
  logic [15:0] maskA = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int doneCount = 0;
  int lastCode = 0;
  bit lastFlag = 0;

  typedef struct {
    int    code;
    bit    flag;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  subflash_seq #(
    .EST_CYC (EST),
    .CRS_CYC (CRS),
    .FINE_CYC(FIN)
  ) u_subflash_seq (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .estCmp   (estCmp),
    .bankCmp  (bankCmp),
    .winBase  (winBase),
    .coarseTap(coarseTap),
    .bankFine (bankFine),
    .result   (result),
    .done     (done),
    .overrange(overrange)
  );

  // analog model: estimator string and shared bank on two ladders
  always_comb begin
    for (int k = 0; k < 6; k++) estCmp[k] = ((vinA + errA) >= 64 * (2 * k + 3));
    for (int j = 0; j < 16; j++) begin
      if (bankFine) bankCmp[j] = ((vinA - int'(coarseTap) * 16) >= j + 1);
      else          bankCmp[j] = (vinA >= (int'(winBase) + j + 1) * 16) ^ maskA[j];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compares each finished code against the scoreboard
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN && done) begin
      doneCount++;
      if (q.size() == 0) begin
        chk(0, "R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(result) == e.code, e.tag, int'(result), e.code);
        chk(overrange == e.flag, {e.tag, " R7 flag"}, int'(overrange), int'(e.flag));
        lastCode = e.code;
        lastFlag = e.flag;
      end
    end
  end

  // driver: computes expected values from the requirements and runs one conversion
  task automatic convert(input int vin, input int err, input logic [15:0] mask,
                         input bit poke, input string tag);
    int e, base, c, coarse, fc, f;
    bit flag;
    exp_t item;
    e = 0;
    for (int k = 0; k < 6; k++) if (vin + err >= 64 * (2 * k + 3)) e++;
    base = 8 * e;
    c = 0;
    for (int j = 0; j < 16; j++) if ((vin >= (base + j + 1) * 16) ^ mask[j]) c++;
    coarse = (base + c > 63) ? 63 : base + c;
    flag = (c == 0 && base != 0) || (c == 16 && base != 48);
    fc = 0;
    for (int j = 0; j < 16; j++) if (vin - coarse * 16 >= j + 1) fc++;
    f = (fc > 15) ? 15 : fc;
    item.code = coarse * 16 + f;
    item.flag = flag;
    item.tag  = tag;
    q.push_back(item);
    vinA = vin; errA = err; maskA = mask;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < EST; i++) begin
      if (poke && i == 0) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    chk(int'(winBase) == base, "R2 window base", int'(winBase), base);
    chk(bankFine == 1'b0, "R4 bank on coarse ladder", int'(bankFine), 0);
    for (int i = 0; i < CRS; i++) @(negedge clk);
    chk(bankFine == 1'b1, "R4 bank on fine ladder", int'(bankFine), 1);
    chk(int'(coarseTap) == coarse, "R3 coarse tap", int'(coarseTap), coarse);
    for (int i = 0; i < FIN - 1; i++) @(negedge clk);
    chk(done == 1'b0, "R8 done early", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R8 done latency", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done width", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(result == '0, "R1 result", int'(result), 0);
    chk(overrange == 1'b0, "R1 overrange", int'(overrange), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(bankFine == 1'b0, "R1 bankFine", int'(bankFine), 0);
    chk(winBase == '0, "R1 winBase", int'(winBase), 0);

    convert(0,    0, '0, 0, "R4 bottom code");
    convert(1023, 0, '0, 0, "R4 top code");
    convert(512,  0, '0, 0, "R3 midscale");
    convert(191,  0, '0, 0, "R2 below first threshold");
    convert(192,  0, '0, 0, "R2 at first threshold");
    convert(703,  0, '0, 0, "R3 window interior");
    convert(832,  0, '0, 0, "R2 top window");
    convert(357,  0, '0, 0, "R4 fine digits");
    convert(704, -64, '0, 0, "R5 estimate low by 64");
    convert(831,  64, '0, 0, "R5 estimate high by 64");
    convert(200, -64, '0, 0, "R5 low window edge");
    convert(960, -64, '0, 0, "R5 top window low estimate");
    convert(100, 400, '0, 0, "R7 all zeros inner edge");
    convert(900, -500, '0, 0, "R7 all ones inner edge");
    convert(500,  0, 16'h0004, 0, "R6 bubble in coarse bank");
    convert(600,  0, 16'h0020, 0, "R6 second bubble");
    convert(420,  0, '0, 1, "R9 start during conversion");
    convert(777,  0, '0, 0, "R9 conversion after ignored start");

    // R10: result and flag hold while inputs move and no conversion runs
    for (int i = 0; i < 6; i++) begin
      vinA = 37 * i + 5;
      @(negedge clk);
    end
    chk(int'(result) == lastCode, "R10 result hold", int'(result), lastCode);
    chk(overrange == lastFlag, "R10 flag hold", int'(overrange), int'(lastFlag));
    chk(q.size() == 0, "R9 pending conversions", q.size(), 0);
    chk(doneCount == 18, "R9 done count", doneCount, 18);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule